// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block takes a demodulated infrared receive line, which is high while a burst is present, and turns one pulse-distance frame into a 16-bit address and a 16-bit command. A metastability synchroniser and a tick-counting glitch filter come first. An edge timer then measures each high interval (mark) and each low interval (space) in prescaled ticks. A small state machine checks these measurements against target widths, each with a symmetric tolerance.

A frame starts with a long header mark and a header space. Thirty-two data symbols follow, each a short mark and a space whose length carries the bit, and a closing mark ends the frame. When the thirty-second symbol is accepted, the decoder strobes a one-cycle valid pulse and holds the decoded fields on its outputs. A malformed symbol, or a line that stays still too long partway through a frame, gives a one-cycle error pulse, and the decoder searches for a header again. All widths are parameters in ticks. The defaults assume a prescaler of 100 on an 80 MHz clock, which gives 0.8 ticks per microsecond.

Top module: `irpd_decoder`

## Requirements
- R1: The first symbol of every frame must be a header, with a mark within the window of HDR_MARK_TK and a space within the window of HDR_SPACE_TK. Any other first symbol pulses frame_error_o and is not decoded. The following mark is treated as a new header candidate, so a later good frame still decodes.
- R2: A measured duration d matches a target t only when t-TOL_TK < d < t+TOL_TK. Both window edges are excluded.
- R3: A data symbol whose mark matches BIT_MARK_TK decodes as bit 1 if its space matches ONE_SPACE_TK, and as bit 0 if its space matches ZERO_SPACE_TK. Any other data symbol pulses frame_error_o, and the decoder returns to header search.
- R4: Data bit k (0-based, in order of arrival) goes to addr_o[k] for k<16 and to cmd_o[k-16] for k>=16, so both fields arrive least significant bit first.
- R5: frame_valid_o is high for exactly one cycle, in the cycle after the filtered rising edge that ends the thirty-second data space. addr_o and cmd_o change only in that cycle and otherwise hold their last values.
- R6: If the filtered line stays in one level for more than IDLE_TK ticks during a mark or a data space, frame_error_o pulses once and the capture ends. The idle line after a completed frame raises no error.
- R7: The glitch filter changes its output level only after the synchronised input has differed from it for glitch_ticks_i consecutive ticks. Shorter pulses have no effect, and longer ones are delayed at both edges by the same amount.
- R8: The interval counter saturates at 2^CNT_W-1 and never wraps while the line holds still. A line held high beyond that count gives a single error pulse.
- R9: During and after reset, frame_valid_o and frame_error_o are 0 and addr_o and cmd_o are 0.
- R10: frame_valid_o and frame_error_o are never high in the same cycle, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_line_i | input | 1 | Demodulated receive line, high during a burst |
| glitch_ticks_i | input | FILT_W (8) | Minimum pulse length, in ticks, that the filter passes (100 for the default tick) |
| frame_valid_o | output | 1 | One-cycle strobe when a full frame is decoded |
| frame_error_o | output | 1 | One-cycle strobe on a rejected symbol or a mid-frame timeout |
| addr_o | output | ADDR_W (16) | Decoded address, held until the next valid |
| cmd_o | output | CMD_W (16) | Decoded command, held until the next valid |

## Verification
A raw edge reaches the filtered line after the two synchroniser stages plus glitch_ticks_i ticks. The valid or error strobe then follows one cycle after the filtered edge that completes the symbol, and a timeout error follows one cycle after the interval count passes IDLE_TK. Every edge has the same delay, so the measured widths equal the widths driven. This lets the bench place durations exactly one tick inside and exactly on each window edge. The strobes are not sampled at one predicted cycle. Instead, falling-edge monitors count them over a window that covers the whole frame plus an idle gap longer than the timeout and the filter delay combined. The bench then compares those counts and the captured fields with the expected ones.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

  typedef enum logic [1:0] {ST_WAIT, ST_MARK, ST_SPACE, ST_TAIL} irpd_state_e;
  typedef enum logic [1:0] {SYM_BAD, SYM_ZERO, SYM_ONE} irpd_sym_e;

  // strict window test: tgt-tol < dur < tgt+tol, written to avoid underflow
  function automatic logic in_window(input int unsigned dur,
                                     input int unsigned tgt,
                                     input int unsigned tol);
    return ((dur + tol) > tgt) && (dur < (tgt + tol));
  endfunction

  function automatic irpd_sym_e classify_bit(input int unsigned mark,
                                             input int unsigned space,
                                             input int unsigned mark_tk,
                                             input int unsigned one_tk,
                                             input int unsigned zero_tk,
                                             input int unsigned tol);
    if (!in_window(mark, mark_tk, tol))  return SYM_BAD;
    if (in_window(space, one_tk, tol))   return SYM_ONE;
    if (in_window(space, zero_tk, tol))  return SYM_ZERO;
    return SYM_BAD;
  endfunction

endpackage

// File: rtl/irpd_tick_gen.sv
module irpd_tick_gen #(
  parameter int PRESCALE = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt;

  assign tick_o = (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (tick_o) pcnt <= '0;
    else             pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/irpd_glitch_filter.sv
module irpd_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              raw_i,
  input  logic [FILT_W-1:0] thresh_i,
  output logic              lvl_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_W-1:0]      fcnt;
  logic                   sync_lvl, differ, commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= raw_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign sync_lvl = sync_q[SYNC_STAGES-1];
  assign differ   = (sync_lvl != lvl_o);
  assign commit   = differ && tick_i &&
                    (({1'b0, fcnt} + 1'b1) >= {1'b0, thresh_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt  <= '0;
      lvl_o <= 1'b0;
    end else if (!differ) begin
      fcnt <= '0;
    end else if (commit) begin
      lvl_o <= sync_lvl;
      fcnt  <= '0;
    end else if (tick_i && (fcnt != '1)) begin
      fcnt <= fcnt + 1'b1;
    end
  end

  // filtered level moves only toward a differing synchronised input
  p_follow_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl == lvl_o) |=> $stable(lvl_o));
  // filtered level moves only on a tick
  p_tick_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(lvl_o));
endmodule

// File: rtl/irpd_edge_timer.sv
module irpd_edge_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             lvl_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic lvl_d, edge_ev;

  assign edge_ev = lvl_i ^ lvl_d;
  assign rise_o  = lvl_i & ~lvl_d;
  assign fall_o  = ~lvl_i & lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      cnt_o <= '0;
    end else begin
      lvl_d <= lvl_i;
      // count 1 on the edge cycle so the value seen at the next edge is the full width
      if (edge_ev)                            cnt_o <= CNT_W'(1);
      else if (tick_i && (cnt_o != CNT_MAX))  cnt_o <= cnt_o + 1'b1;
    end
  end

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX && !edge_ev) |=> (cnt_o == CNT_MAX));
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_ev |=> (cnt_o >= $past(cnt_o)));
endmodule

// File: rtl/irpd_frame_fsm.sv
module irpd_frame_fsm
  import irpd_pkg::*;
#(
  parameter int          CNT_W         = 15,
  parameter int          ADDR_W        = 16,
  parameter int          CMD_W         = 16,
  parameter int unsigned HDR_MARK_TK   = 7200,
  parameter int unsigned HDR_SPACE_TK  = 3600,
  parameter int unsigned BIT_MARK_TK   = 448,
  parameter int unsigned ONE_SPACE_TK  = 1352,
  parameter int unsigned ZERO_SPACE_TK = 448,
  parameter int unsigned TOL_TK        = 128,
  parameter int unsigned IDLE_TK       = 7600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              valid_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CMD_W-1:0]  cmd_o
);
  localparam int FRAME_BITS = ADDR_W + CMD_W;
  localparam int NB_W       = $clog2(FRAME_BITS);
  localparam logic [NB_W-1:0] LAST_BIT = NB_W'(FRAME_BITS - 1);

  irpd_state_e           st;
  logic [CNT_W-1:0]      mark_len;
  logic [FRAME_BITS-1:0] shreg;
  logic [NB_W-1:0]       nbits;
  logic                  hdr_seen;

  logic                  timeout, hdr_ok;
  irpd_sym_e             sym;
  logic [FRAME_BITS-1:0] shifted;

  assign timeout = (32'(cnt_i) > IDLE_TK);
  assign hdr_ok  = in_window(32'(mark_len), HDR_MARK_TK, TOL_TK) &&
                   in_window(32'(cnt_i), HDR_SPACE_TK, TOL_TK);
  assign sym     = classify_bit(32'(mark_len), 32'(cnt_i), BIT_MARK_TK,
                                ONE_SPACE_TK, ZERO_SPACE_TK, TOL_TK);
  // new bit enters at the top; after the last shift bit 0 is the first bit received
  assign shifted = {(sym == SYM_ONE), shreg[FRAME_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_WAIT;
      mark_len <= '0;
      shreg    <= '0;
      nbits    <= '0;
      hdr_seen <= 1'b0;
      valid_o  <= 1'b0;
      error_o  <= 1'b0;
      addr_o   <= '0;
      cmd_o    <= '0;
    end else begin
      valid_o <= 1'b0;
      error_o <= 1'b0;
      case (st)
        ST_WAIT: if (rise_i) begin
          st       <= ST_MARK;
          hdr_seen <= 1'b0;
          nbits    <= '0;
        end
        ST_MARK: if (fall_i) begin
          mark_len <= cnt_i;
          st       <= ST_SPACE;
        end else if (timeout) begin
          error_o <= 1'b1;
          st      <= ST_TAIL;
        end
        ST_SPACE: if (rise_i) begin
          st <= ST_MARK;
          if (!hdr_seen) begin
            if (hdr_ok) hdr_seen <= 1'b1;
            else        error_o  <= 1'b1;
          end else if (sym == SYM_BAD) begin
            error_o  <= 1'b1;
            hdr_seen <= 1'b0;
            nbits    <= '0;
          end else begin
            shreg <= shifted;
            nbits <= nbits + 1'b1;
            if (nbits == LAST_BIT) begin
              valid_o <= 1'b1;
              addr_o  <= shifted[ADDR_W-1:0];
              cmd_o   <= shifted[FRAME_BITS-1:ADDR_W];
              st      <= ST_TAIL;
            end
          end
        end else if (timeout) begin
          error_o <= 1'b1;
          st      <= ST_TAIL;
        end
        default: if (!lvl_i && timeout) st <= ST_WAIT;
      endcase
    end
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && error_o));
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_error_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o);
  p_valid_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(rise_i) && $past(st == ST_SPACE)));
  p_fields_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(addr_o) && $stable(cmd_o)));
  p_mark_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MARK && !fall_i && timeout) |=> (error_o && st == ST_TAIL));
  p_tail_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TAIL) |=> !error_o);
endmodule

// File: rtl/irpd_decoder.sv
module irpd_decoder #(
  parameter int          PRESCALE      = 100,
  parameter int          SYNC_STAGES   = 2,
  parameter int          FILT_W        = 8,
  parameter int          CNT_W         = 15,
  parameter int          ADDR_W        = 16,
  parameter int          CMD_W         = 16,
  parameter int unsigned HDR_MARK_TK   = 7200,
  parameter int unsigned HDR_SPACE_TK  = 3600,
  parameter int unsigned BIT_MARK_TK   = 448,
  parameter int unsigned ONE_SPACE_TK  = 1352,
  parameter int unsigned ZERO_SPACE_TK = 448,
  parameter int unsigned TOL_TK        = 128,
  parameter int unsigned IDLE_TK       = 7600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_line_i,
  input  logic [FILT_W-1:0] glitch_ticks_i,
  output logic              frame_valid_o,
  output logic              frame_error_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CMD_W-1:0]  cmd_o
);
  logic             tick, lvl, rise, fall;
  logic [CNT_W-1:0] cnt;

  irpd_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  irpd_glitch_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_W(FILT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .raw_i(ir_line_i),
    .thresh_i(glitch_ticks_i), .lvl_o(lvl));

  irpd_edge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .lvl_i(lvl),
    .rise_o(rise), .fall_o(fall), .cnt_o(cnt));

  irpd_frame_fsm #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W),
    .HDR_MARK_TK(HDR_MARK_TK), .HDR_SPACE_TK(HDR_SPACE_TK),
    .BIT_MARK_TK(BIT_MARK_TK), .ONE_SPACE_TK(ONE_SPACE_TK),
    .ZERO_SPACE_TK(ZERO_SPACE_TK), .TOL_TK(TOL_TK), .IDLE_TK(IDLE_TK)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_i(rise), .fall_i(fall),
    .cnt_i(cnt), .valid_o(frame_valid_o), .error_o(frame_error_o),
    .addr_o(addr_o), .cmd_o(cmd_o));
endmodule

// File: tb/test_irpd_decoder.sv
`timescale 1ns/1ps
module test_irpd_decoder;
  localparam int HM = 900, HS = 450, BM = 56, ONE = 169, ZERO = 56;
  localparam int TOL = 16, IDLE = 950, CW = 11, GAP = 1200;

  // {frame word as sent bit0 first, expected address, expected command}
  localparam logic [63:0] VEC [4] = '{
    {32'h1234_5678, 16'h5678, 16'h1234},
    {32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF},
    {32'h0000_0000, 16'h0000, 16'h0000},
    {32'h8001_4002, 16'h4002, 16'h8001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir = 1'b0;
  logic [7:0]  gth = 8'd4;
  logic        frame_valid, frame_error;
  logic [15:0] addr, cmd;

  int n_chk = 0, n_err = 0, n_valid = 0, n_error = 0;
  logic [15:0] cap_a = '0, cap_c = '0;

  always #2 clk = ~clk;

  irpd_decoder #(
    .PRESCALE(1), .CNT_W(CW), .HDR_MARK_TK(HM), .HDR_SPACE_TK(HS),
    .BIT_MARK_TK(BM), .ONE_SPACE_TK(ONE), .ZERO_SPACE_TK(ZERO),
    .TOL_TK(TOL), .IDLE_TK(IDLE)
  ) i_irpd_decoder (
    .clk(clk), .rst_n(rst_n), .ir_line_i(ir), .glitch_ticks_i(gth),
    .frame_valid_o(frame_valid), .frame_error_o(frame_error),
    .addr_o(addr), .cmd_o(cmd));

  always @(negedge clk) if (rst_n) begin
    if (frame_valid) begin n_valid++; cap_a = addr; cap_c = cmd; end
    if (frame_error) n_error++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic hold(input logic v, input int n);
    ir = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    n_valid = 0; n_error = 0;
  endtask

  // glen>0 splits the header mark with a low pulse of glen cycles
  task automatic frame(input logic [31:0] w, input int hm, input int hs,
                       input int idx, input int bmo, input int bso,
                       input int nb, input int glen);
    if (glen > 0) begin hold(1, 400); hold(0, glen); hold(1, hm - 400 - glen); end
    else hold(1, hm);
    hold(0, hs);
    for (int i = 0; i < nb; i++) begin
      if (i == idx) begin hold(1, bmo); hold(0, bso); end
      else begin hold(1, BM); hold(0, w[i] ? ONE : ZERO); end
    end
    if (nb == 32) hold(1, BM);
    hold(0, GAP);
  endtask

  task automatic good(input logic [31:0] w, input string req);
    clr();
    frame(w, HM, HS, -1, 0, 0, 32, 0);
    chk({req, " valid count"}, n_valid, 1);
    chk({req, " error count"}, n_error, 0);
    chk({req, " addr"}, cap_a, w[15:0]);
    chk({req, " cmd"}, cap_c, w[31:16]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R5 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 valid in reset", frame_valid, 0);
    chk("R9 error in reset", frame_error, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 addr after reset", addr, 0);
    chk("R9 cmd after reset", cmd, 0);
    chk("R9 strobes after reset", frame_valid | frame_error, 0);

    // table of frames: R3 bit values, R4 field order, R5 single strobe
    for (int v = 0; v < 4; v++) begin
      clr();
      frame(VEC[v][63:32], HM, HS, -1, 0, 0, 32, 0);
      chk("R5 valid once", n_valid, 1);
      chk("R10 no error", n_error, 0);
      chk("R4 addr", cap_a, VEC[v][31:16]);
      chk("R4 cmd", cap_c, VEC[v][15:0]);
    end

    // R2 inner edges accepted: header and bit 5 (a zero) one tick inside
    clr();
    frame(32'h0F0F_3C1F, HM + TOL - 1, HS - TOL + 1, 5, BM + TOL - 1, ZERO + TOL - 1, 32, 0);
    chk("R2 inner edge valid", n_valid, 1);
    chk("R2 inner edge addr", cap_a, 16'h3C1F);
    // R2 bit 6 (a one) with short mark and long space inside window
    clr();
    frame(32'h0000_0040, HM, HS, 6, BM - TOL + 1, ONE + TOL - 1, 32, 0);
    chk("R2 one inner edge valid", n_valid, 1);
    chk("R2 one inner edge addr", cap_a, 16'h0040);
    // R2/R3 space exactly on the outer edge is rejected
    clr();
    frame(32'h0000_0000, HM, HS, 3, BM, ZERO + TOL, 32, 0);
    chk("R3 edge space valid", n_valid, 0);
    chk("R3 edge space error", int'(n_error != 0), 1);
    // R1/R2 header space on outer edge rejected
    clr();
    frame(32'h1111_2222, HM, HS + TOL, -1, 0, 0, 32, 0);
    chk("R1 header edge valid", n_valid, 0);
    chk("R1 header edge error", int'(n_error != 0), 1);
    // R1 wrong header mark
    clr();
    frame(32'hAAAA_5555, 700, HS, -1, 0, 0, 32, 0);
    chk("R1 bad header valid", n_valid, 0);
    chk("R1 bad header error", int'(n_error != 0), 1);
    chk("R5 fields held after errors", addr, 16'h0040);

    // R7 short glitch ignored (also R1 recovery after errors)
    clr();
    frame(32'hBEEF_CAFE, HM, HS, -1, 0, 0, 32, 3);
    chk("R7 short glitch valid", n_valid, 1);
    chk("R7 short glitch addr", cap_a, 16'hCAFE);
    chk("R7 short glitch cmd", cap_c, 16'hBEEF);
    // R7 pulse longer than threshold splits the header
    clr();
    frame(32'hBEEF_CAFE, HM, HS, -1, 0, 0, 32, 6);
    chk("R7 long glitch valid", n_valid, 0);
    chk("R7 long glitch error", int'(n_error != 0), 1);

    // R6 frame cut after 10 bits: one timeout error
    clr();
    frame(32'h0000_03FF, HM, HS, -1, 0, 0, 10, 0);
    chk("R6 timeout error", n_error, 1);
    chk("R6 timeout valid", n_valid, 0);

    // R8 line stuck high past the counter range: single error
    clr();
    hold(1, 2300);
    hold(0, GAP);
    chk("R8 stuck high error", n_error, 1);
    chk("R8 stuck high valid", n_valid, 0);
    good(32'h7E57_0C0D, "R8 recovery");

    summary();
    $finish;
  end
endmodule